// File: doc/BRIEF.md
# MDIO Management Access Controller

This block turns one packed 32-bit access word into a single clause-22 management transaction on a two-wire PHY management bus. Software writes the word with the request flag set. The controller then generates the management clock and shifts out the complete serial frame. On a read, it releases the data line for the PHY's reply and samples the reply on each rising clock edge.

When the frame ends, the request flag drops back to zero. For a read, the sixteen returned bits now sit in the low half of the word. Software polls the flag and uses the data once the flag reads zero. The management clock runs at the system clock divided by `DIV`, which defaults to 8.

Top module: `mdio_access_ctrl`

## Requirements
- R1: After reset, the readback word is 0, the management clock is low and the data output-enable is low.
- R2: A write with bit 31 set while idle starts a transaction. Bit 31 then reads 1 from the next cycle and returns to 0 exactly 64*DIV cycles after the accepting edge.
- R3: A write with bit 31 clear while idle stores bits 30 and 25:0 but starts no transaction: the management clock stays low.
- R4: A write transaction (bit 30 = 1) drives, MSB first, 32 ones, start `01`, opcode `01`, PHY address (bits 25:21), register address (bits 20:16), turnaround `10`, then data bits 15:0, with output-enable high for all 64 bits.
- R5: A read transaction (bit 30 = 0) drives the same preamble, start, addresses and opcode `10`. Output-enable is low from the first turnaround bit (bit 46) to the end of the frame.
- R6: On a read, the bit presented on the data input at each of the last 16 rising clock edges is captured MSB first. The result appears in bits 15:0 when bit 31 clears, and bits 30 and 25:16 are kept.
- R7: Each frame bit lasts DIV system cycles, with the clock low for the first DIV/2 and high for the last DIV/2. The data output changes only at bit boundaries, and the clock is low when idle.
- R8: A write of any value while a transaction is in progress is ignored: it changes neither the frame nor the stored word.
- R9: Readback bits 29:26 are always 0, and bit 30 returns the stored direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Access word write strobe |
| wr_data_i | input | 32 | Access word write data |
| rd_data_o | output | 32 | Access word readback |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output-enable |
| mdio_i | input | 1 | Management data in |

## Verification
The request flag rises on the cycle after the accepting edge and falls exactly 64*DIV cycles after it. For a read, the data field changes on that same edge. The bench samples on the falling system edge at both the last busy cycle and the first idle cycle.

Frame bits are captured on every rising management clock, so frame content needs no absolute cycle count. The PHY model drives each reply bit one full bit period before the edge that samples it. Expected frames and output-enable masks are queued by the driver and compared once the 64th rising edge has been seen.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_SLOT    = 46;
  localparam int LAST_SLOT  = 63;

  function automatic logic [FRAME_BITS-1:0] make_frame(
      input logic wr, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic slot_end_o
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign rise_o     = run_i && (cnt_q == CW'(HALF - 1));
  assign slot_end_o = run_i && (cnt_q == CW'(DIV - 1));
  assign mdc_o      = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (run_i) begin
      cnt_q <= slot_end_o ? '0 : cnt_q + 1'b1;
      if (rise_o)          mdc_q <= 1'b1;
      else if (slot_end_o) mdc_q <= 1'b0;
    end else begin
      mdc_q <= 1'b0;
    end
  end

  assert_mdc_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  read_i,
  input  logic                  rise_i,
  input  logic                  slot_end_i,
  input  logic                  mdio_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic [15:0]           rx_o
);
  localparam logic [5:0] LAST = 6'(LAST_SLOT);
  localparam logic [5:0] TA   = 6'(TA_SLOT);

  logic                  busy_q, rd_q;
  logic [5:0]            slot_q;
  logic [FRAME_BITS-1:0] tx_q;
  logic [15:0]           rx_q;

  assign done_o    = busy_q && slot_end_i && (slot_q == LAST);
  assign busy_o    = busy_q;
  assign mdio_o    = tx_q[FRAME_BITS-1];
  assign mdio_oe_o = busy_q && !(rd_q && (slot_q >= TA));
  assign rx_o      = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      slot_q <= '0;
      tx_q   <= '1;
      rx_q   <= '0;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        rd_q   <= read_i;
        slot_q <= '0;
        tx_q   <= frame_i;
      end else if (busy_q && slot_end_i) begin
        if (slot_q == LAST) begin
          busy_q <= 1'b0;
          tx_q   <= '1;
        end else begin
          slot_q <= slot_q + 1'b1;
          tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b1};
        end
      end
      // last 16 rising edges of the frame leave the reply in rx_q
      if (busy_q && rise_i) rx_q <= {rx_q[14:0], mdio_i};
    end
  end

  assert_mdio_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !slot_end_i) |=> $stable(mdio_o));

  assert_read_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rd_q && rise_i && (slot_q >= TA)) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_access_ctrl.sv
module mdio_access_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic        busy, done, rise, slot_end, start;
  logic [15:0] rx_word;
  logic        wr_q;
  logic [4:0]  phy_q, reg_q;
  logic [15:0] data_q;
  logic [FRAME_BITS-1:0] frame;

  assign start = wr_en_i && !busy && wr_data_i[31];
  assign frame = make_frame(wr_data_i[30], wr_data_i[25:21], wr_data_i[20:16], wr_data_i[15:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
    end else if (wr_en_i && !busy) begin
      wr_q   <= wr_data_i[30];
      phy_q  <= wr_data_i[25:21];
      reg_q  <= wr_data_i[20:16];
      data_q <= wr_data_i[15:0];
    end else if (done && !wr_q) begin
      data_q <= rx_word;
    end
  end

  assign rd_data_o = {busy, wr_q, 4'b0000, phy_q, reg_q, data_q};

  mdio_mdc_gen #(.DIV(DIV)) u_mdc (
    .clk_i, .rst_ni, .start_i(start), .run_i(busy),
    .mdc_o, .rise_o(rise), .slot_end_o(slot_end)
  );

  mdio_frame_seq u_seq (
    .clk_i, .rst_ni, .start_i(start), .frame_i(frame), .read_i(!wr_data_i[30]),
    .rise_i(rise), .slot_end_i(slot_end), .mdio_i,
    .busy_o(busy), .done_o(done), .mdio_o, .mdio_oe_o, .rx_o(rx_word)
  );

  assert_start_sets_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_data_o[31] && wr_data_i[31]) |=> rd_data_o[31]);

  assert_done_clears_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !rd_data_o[31]);

  assert_busy_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i) |=> ($stable(phy_q) && $stable(reg_q) && $stable(wr_q)));
endmodule

// File: tb/mdio_access_ctrl_tb.sv
module mdio_access_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_TB     = 8;
  localparam int HALF       = DIV_TB / 2;
  localparam int FRAME_CYC  = 64 * DIV_TB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  logic [63:0] exp_bits_q[$], exp_oe_q[$];
  string       exp_tag_q[$];
  logic [15:0] phy_resp = '0;
  int rise_cnt = 0, total_rises = 0, hi_cnt = 0, bad_hi = 0;
  logic mdc_prev = 1'b0;
  logic [63:0] cap_bits, cap_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_access_ctrl #(.DIV(DIV_TB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: capture each frame bit on rising MDC, model PHY reply, compare with scoreboard
  always @(negedge clk) begin
    if (mdc_o && !mdc_prev) begin
      cap_bits[63-rise_cnt] = mdio_o;
      cap_oe[63-rise_cnt]   = mdio_oe_o;
      rise_cnt++;
      total_rises++;
      if (rise_cnt == 64) begin
        if (exp_bits_q.size() == 0) begin
          check(1'b0, "R8 unexpected frame", cap_bits, 64'h0);
        end else begin
          logic [63:0] eb, eo;
          string tag;
          eb = exp_bits_q.pop_front();
          eo = exp_oe_q.pop_front();
          tag = exp_tag_q.pop_front();
          check(cap_oe == eo, {tag, " oe mask"}, cap_oe, eo);
          check((cap_bits & eo) == (eb & eo), {tag, " frame bits"}, cap_bits & eo, eb & eo);
        end
        rise_cnt = 0;
      end
      mdio_i = (rise_cnt >= 48) ? phy_resp[63-rise_cnt] : 1'b1;
    end
    if (mdc_o) hi_cnt++;
    if (!mdc_o && mdc_prev) begin
      if (hi_cnt != HALF) bad_hi++;
      hi_cnt = 0;
    end
    mdc_prev = mdc_o;
  end

  function automatic logic [63:0] frame_of(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b01, (w[30] ? 2'b01 : 2'b10), w[25:21], w[20:16], 2'b10, w[15:0]};
  endfunction

  // driver: one full transaction, scoreboard push, flag timing and final readback
  task automatic run_access(input logic [31:0] word, input logic [15:0] resp, input bit poke_busy);
    logic [31:0] exp_after;
    exp_after = word[30] ? {1'b0, 1'b1, 4'b0000, word[25:0]}
                         : {1'b0, 1'b0, 4'b0000, word[25:16], resp};
    @(negedge clk);
    wr_en = 1'b1; wr_data = word; phy_resp = resp;
    exp_bits_q.push_back(frame_of(word));
    exp_oe_q.push_back(word[30] ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, {18{1'b0}}});
    exp_tag_q.push_back(word[30] ? "R4" : "R5");
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data[31] == 1'b1, "R2 flag set after request", rd_data, 1);
    for (int i = 1; i <= FRAME_CYC - 2; i++) begin
      @(negedge clk);
      if (poke_busy && i == 100) begin wr_en = 1'b1; wr_data = 32'hFFFF_FFFF; end
      if (poke_busy && i == 101) wr_en = 1'b0;
    end
    @(negedge clk);
    check(rd_data[31] == 1'b1, "R2 flag still set on last busy cycle", rd_data, 1);
    @(negedge clk);
    check(rd_data[31] == 1'b0, "R2 flag clear at 64*DIV", rd_data, 0);
    check(rd_data == exp_after, word[30] ? (poke_busy ? "R8 readback" : "R9 readback")
                                          : "R6 read data", rd_data, exp_after);
    check(bad_hi == 0, "R7 MDC high width", bad_hi, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 32'h0, "R1 readback", rd_data, 0);
    check(mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R1 mdc/oe", {mdc_o, mdio_oe_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 32'h0 && mdc_o == 1'b0 && mdio_oe_o == 1'b0, "R1 after release", rd_data, 0);

    run_access(32'hC0A0_9000, 16'h0000, 1'b0);  // R4: write PHY 5 reg 0
    run_access(32'hC0C0_9000, 16'h0000, 1'b0);  // R4: write PHY 6 reg 0
    run_access(32'h80C1_1234, 16'hA5C3, 1'b0);  // R5/R6 read
    run_access(32'h83FF_0000, 16'h8001, 1'b0);  // R6 edge bits
    run_access(32'hFCAB_CDEF, 16'h0000, 1'b0);  // R9 reserved bits written as ones
    run_access(32'hC2B3_5A5A, 16'h0000, 1'b1);  // R8 write while busy

    // R3: request flag clear -> fields stored, no frame
    begin
      int rises_before;
      rises_before = total_rises;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h4123_4567;
      @(negedge clk);
      wr_en = 1'b0;
      check(rd_data == 32'h4123_4567, "R3 fields stored without start", rd_data, 32'h4123_4567);
      repeat (3 * DIV_TB) @(negedge clk);
      check(total_rises == rises_before && mdc_o == 1'b0, "R3 no MDC activity",
            total_rises, rises_before);
      check(rd_data[31] == 1'b0, "R3 flag stays clear", rd_data, 0);
    end

    repeat (2 * DIV_TB) @(negedge clk);
    check(exp_bits_q.size() == 0, "R4 all queued frames seen", exp_bits_q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (R2) actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule